// File: doc/BRIEF.md
# Paged NIC Host Register File

This block is the byte-wide host register window of a legacy Ethernet controller. A host reaches sixteen locations through a 4-bit offset. Location 0 is always the command register. Its two top bits choose the page that locations 1 to 15 decode into. The same offset can name a different register for a read than for a write, and a different register again on each page.

The block stores the receive ring limits and boundary, the current receive page, the transmit start page and byte count, the remote DMA start address and byte count, the receive, transmit and data configuration bytes, the station address and the multicast filter. It also keeps an interrupt status byte (write-one-to-clear) and its mask, and drives one interrupt line.

A transmit request in the command register is acknowledged at once. The block posts a successful transmit status and raises a one-cycle request, with the start page and length, toward a transmit engine outside the block. Frame movement, buffer memory and remote DMA data transfer happen elsewhere.

Top module: `nic_regfile`

## Requirements
- R1: After reset the command register reads 0x22 (page 0, start set). The mask reads 0x00 and the status reads 0x80. All multicast filter bytes read 0xFF, and `irq`, `tx_req` and `acc_err` are low.
- R2: Command bits 7:6 select the page for offsets 1 to 15. Offset 0 is the command register on every page, including page 3, for both reads and writes.
- R3: Page 0 writes go to these registers: ring start (1), ring stop (2), boundary (3), transmit start page (4), transmit count low/high (5/6), status (7), remote start address low/high (8/9), remote byte count low/high (A/B), receive config (C), transmit config (D), data config (E) and mask (F). Page 2 reads return ring start (1), ring stop (2), transmit start page (4), receive config (C), transmit config (D), data config (E) and mask (F). The boundary reads back at page 0 offset 3.
- R4: On page 1, offsets 1 to 6 are the six station address bytes, offset 7 is the current receive page, and offsets 8 to F are the eight multicast bytes. All are readable and writable.
- R5: A status write clears every status bit 6:0 whose written bit is 1. Bit 7 is never changed by a status write.
- R6: `irq` is high exactly when status AND mask has a set bit among bits 6:0, and it is updated on the same edge as the write that changes either register. Status bit 7 never raises `irq`.
- R7: A command write with bit 0 (stop) clear clears status bit 7. A command write with stop set leaves it unchanged.
- R8: A command write with stop clear and bit 2 (transmit) set makes page 0 offset 4 read 0x01. It also sets status bit 1, and the command register reads back with bit 2 clear.
- R9: A command write with stop clear, bits 5:3 equal to 1, 2 or 3, and a remote byte count of zero sets status bit 6. A nonzero count, the value 4, or stop set leaves bit 6 unchanged.
- R10: A write to an unmapped offset, or to offsets 1 to F while page 3 is selected, changes nothing. A read of such a location returns 0x00. Either access raises `acc_err` for one cycle.
- R11: `rdata` is loaded on the clock edge that samples `rd_en` and holds its value until the next read.
- R12: On page 0, offsets 1, 2, 5, 6, C, D, E and F read 0x00, and A and B are unmapped for reads. Offsets 8/9 return the remote start address bytes. None of these mapped reads raises `acc_err`.
- R13: An accepted transmit command (R8) pulses `tx_req` for one cycle on the same edge. `tx_page` and `tx_len` carry the programmed transmit start page and the 16-bit transmit byte count.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| wr_en | input | 1 | Register write strobe |
| rd_en | input | 1 | Register read strobe |
| addr | input | AW (4) | Register offset within the window |
| wdata | input | DW (8) | Write data |
| rdata | output | DW (8) | Registered read data |
| irq | output | 1 | Interrupt request, registered |
| acc_err | output | 1 | One-cycle flag for an unmapped access |
| tx_req | output | 1 | One-cycle transmit request |
| tx_page | output | DW (8) | Transmit start page |
| tx_len | output | 2*DW (16) | Transmit byte count |

## Verification
The bench builds the block with its defaults: 8-bit data, a 4-bit offset, six station address bytes and eight multicast bytes. With these values page 1 is fully populated, so the two boundaries between station address, current page and multicast filter fall on real offsets. Every page-1 location is exercised. The 16-bit counts make the zero-count remote DMA rule reachable both with a low byte set and with both bytes clear.

// File: rtl/nic_regfile_pkg.sv
package nic_regfile_pkg;

  typedef enum logic [4:0] {
    R_NONE,
    R_CMD,
    R_PSTART,
    R_PSTOP,
    R_BND,
    R_TPSR,
    R_TCNT_LO,
    R_TCNT_HI,
    R_ISR,
    R_RSA_LO,
    R_RSA_HI,
    R_RBC_LO,
    R_RBC_HI,
    R_RXCFG,
    R_TXCFG,
    R_DCFG,
    R_IMR,
    R_TSR,
    R_ZERO,
    R_MAC,
    R_CURPG,
    R_MCAST
  } reg_id_e;

  // command register fields
  localparam int CMD_STOP_BIT = 0;
  localparam int CMD_TX_BIT   = 2;
  localparam int CMD_DMA_LSB  = 3;
  localparam int CMD_PAGE_LSB = 6;

  // status bit positions
  localparam int ST_TX_BIT  = 1;
  localparam int ST_DMA_BIT = 6;
  localparam int ST_RST_BIT = 7;

  localparam logic [7:0] CMD_RESET_VAL = 8'h22;
  localparam logic [7:0] ST_RESET_VAL  = 8'h80;
  localparam logic [7:0] ST_IRQ_MASK   = 8'h7F;
  localparam logic [7:0] TSR_OK_VAL    = 8'h01;

endpackage

// File: rtl/nic_page_decode.sv
module nic_page_decode
  import nic_regfile_pkg::*;
#(
  parameter int AW          = 4,
  parameter int MAC_BYTES   = 6,
  parameter int MCAST_BYTES = 8,
  parameter int IDXW        = 3,
  parameter bit IS_WRITE    = 1'b0
) (
  input  logic [1:0]      page,
  input  logic [AW-1:0]   offset,
  output reg_id_e         id,
  output logic [IDXW-1:0] idx
);

  localparam int CURPG_OFF = MAC_BYTES + 1;
  localparam int MC_FIRST  = MAC_BYTES + 2;
  localparam int MC_LAST   = MAC_BYTES + 1 + MCAST_BYTES;

  logic [31:0]     off_i;
  reg_id_e         pg1_id;
  logic [IDXW-1:0] pg1_idx;

  assign off_i = 32'(offset);

  // page 1 is symmetric for reads and writes
  always_comb begin
    pg1_id  = R_NONE;
    pg1_idx = '0;
    if (off_i >= 32'd1 && off_i <= 32'(MAC_BYTES)) begin
      pg1_id  = R_MAC;
      pg1_idx = IDXW'(off_i - 32'd1);
    end else if (off_i == 32'(CURPG_OFF)) begin
      pg1_id = R_CURPG;
    end else if (off_i >= 32'(MC_FIRST) && off_i <= 32'(MC_LAST)) begin
      pg1_id  = R_MCAST;
      pg1_idx = IDXW'(off_i - 32'(MC_FIRST));
    end
  end

  generate
    if (IS_WRITE) begin : g_wr_map
      always_comb begin
        id  = R_NONE;
        idx = '0;
        if (off_i == 32'd0) begin
          id = R_CMD;
        end else begin
          case (page)
            2'd0: begin
              case (off_i)
                32'h1: id = R_PSTART;
                32'h2: id = R_PSTOP;
                32'h3: id = R_BND;
                32'h4: id = R_TPSR;
                32'h5: id = R_TCNT_LO;
                32'h6: id = R_TCNT_HI;
                32'h7: id = R_ISR;
                32'h8: id = R_RSA_LO;
                32'h9: id = R_RSA_HI;
                32'hA: id = R_RBC_LO;
                32'hB: id = R_RBC_HI;
                32'hC: id = R_RXCFG;
                32'hD: id = R_TXCFG;
                32'hE: id = R_DCFG;
                32'hF: id = R_IMR;
                default: id = R_NONE;
              endcase
            end
            2'd1: begin
              id  = pg1_id;
              idx = pg1_idx;
            end
            default: id = R_NONE;
          endcase
        end
      end
    end else begin : g_rd_map
      always_comb begin
        id  = R_NONE;
        idx = '0;
        if (off_i == 32'd0) begin
          id = R_CMD;
        end else begin
          case (page)
            2'd0: begin
              case (off_i)
                32'h3: id = R_BND;
                32'h4: id = R_TSR;
                32'h7: id = R_ISR;
                32'h8: id = R_RSA_LO;
                32'h9: id = R_RSA_HI;
                32'h1, 32'h2, 32'h5, 32'h6,
                32'hC, 32'hD, 32'hE, 32'hF: id = R_ZERO;
                default: id = R_NONE;
              endcase
            end
            2'd1: begin
              id  = pg1_id;
              idx = pg1_idx;
            end
            2'd2: begin
              case (off_i)
                32'h1: id = R_PSTART;
                32'h2: id = R_PSTOP;
                32'h4: id = R_TPSR;
                32'hC: id = R_RXCFG;
                32'hD: id = R_TXCFG;
                32'hE: id = R_DCFG;
                32'hF: id = R_IMR;
                default: id = R_NONE;
              endcase
            end
            default: id = R_NONE;
          endcase
        end
      end
    end
  endgenerate

endmodule

// File: rtl/nic_byte_bank.sv
module nic_byte_bank #(
  parameter int          N         = 6,
  parameter int          DW        = 8,
  parameter int          IDXW      = 3,
  parameter logic [7:0]  RESET_VAL = 8'h00
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                we,
  input  logic [IDXW-1:0]     widx,
  input  logic [DW-1:0]       wdata,
  output logic [N-1:0][DW-1:0] q
);

  generate
    for (genvar i = 0; i < N; i++) begin : g_byte
      always_ff @(posedge clk) begin
        if (rst) begin
          q[i] <= DW'(RESET_VAL);
        end else if (we && (widx == IDXW'(i))) begin
          q[i] <= wdata;
        end
      end
    end
  endgenerate

endmodule

// File: rtl/nic_irq_ctrl.sv
module nic_irq_ctrl
  import nic_regfile_pkg::*;
#(
  parameter int DW = 8
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          st_w1c,
  input  logic          mask_wr,
  input  logic [DW-1:0] wdata,
  input  logic          clr_rst_bit,
  input  logic          set_tx,
  input  logic          set_dma,
  output logic [DW-1:0] status,
  output logic [DW-1:0] mask,
  output logic          irq
);

  logic [DW-1:0] status_d;
  logic [DW-1:0] mask_d;

  always_comb begin
    status_d = status;
    if (st_w1c) begin
      status_d = status_d & ~(wdata & DW'(ST_IRQ_MASK));
    end
    if (clr_rst_bit) begin
      status_d[ST_RST_BIT] = 1'b0;
    end
    if (set_tx) begin
      status_d[ST_TX_BIT] = 1'b1;
    end
    if (set_dma) begin
      status_d[ST_DMA_BIT] = 1'b1;
    end
    mask_d = mask_wr ? wdata : mask;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      status <= DW'(ST_RESET_VAL);
      mask   <= '0;
      irq    <= 1'b0;
    end else begin
      status <= status_d;
      mask   <= mask_d;
      irq    <= |(status_d & mask_d & DW'(ST_IRQ_MASK));
    end
  end

endmodule

// File: rtl/nic_regfile.sv
module nic_regfile
  import nic_regfile_pkg::*;
#(
  parameter int DW          = 8,
  parameter int AW          = 4,
  parameter int MAC_BYTES   = 6,
  parameter int MCAST_BYTES = 8
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            wr_en,
  input  logic            rd_en,
  input  logic [AW-1:0]   addr,
  input  logic [DW-1:0]   wdata,
  output logic [DW-1:0]   rdata,
  output logic            irq,
  output logic            acc_err,
  output logic            tx_req,
  output logic [DW-1:0]   tx_page,
  output logic [2*DW-1:0] tx_len
);

  localparam int BANK_MAX = (MAC_BYTES > MCAST_BYTES) ? MAC_BYTES : MCAST_BYTES;
  localparam int IDXW     = (BANK_MAX > 1) ? $clog2(BANK_MAX) : 1;

  reg_id_e         wr_id, rd_id;
  logic [IDXW-1:0] wr_idx, rd_idx;

  logic [DW-1:0]   cmd_q, pstart_q, pstop_q, bnd_q, tpsr_q, curpg_q;
  logic [DW-1:0]   rxcfg_q, txcfg_q, dcfg_q, tsr_q;
  logic [2*DW-1:0] tcnt_q, rsa_q, rbc_q;
  logic [DW-1:0]   isr_q, imr_q;

  logic [MAC_BYTES-1:0][DW-1:0]   mac_q;
  logic [MCAST_BYTES-1:0][DW-1:0] mcast_q;

  logic          cmd_wr, run_wr, tx_go, dma_go;
  logic [2:0]    dma_cmd;
  logic [DW-1:0] rd_val;

  nic_page_decode #(
    .AW(AW), .MAC_BYTES(MAC_BYTES), .MCAST_BYTES(MCAST_BYTES),
    .IDXW(IDXW), .IS_WRITE(1'b1)
  ) u_wr_dec (
    .page(cmd_q[CMD_PAGE_LSB +: 2]), .offset(addr), .id(wr_id), .idx(wr_idx)
  );

  nic_page_decode #(
    .AW(AW), .MAC_BYTES(MAC_BYTES), .MCAST_BYTES(MCAST_BYTES),
    .IDXW(IDXW), .IS_WRITE(1'b0)
  ) u_rd_dec (
    .page(cmd_q[CMD_PAGE_LSB +: 2]), .offset(addr), .id(rd_id), .idx(rd_idx)
  );

  // command decode
  assign cmd_wr  = wr_en && (wr_id == R_CMD);
  assign run_wr  = cmd_wr && !wdata[CMD_STOP_BIT];
  assign tx_go   = run_wr && wdata[CMD_TX_BIT];
  assign dma_cmd = wdata[CMD_DMA_LSB +: 3];
  assign dma_go  = run_wr && (dma_cmd >= 3'd1) && (dma_cmd <= 3'd3) && (rbc_q == '0);

  always_ff @(posedge clk) begin
    if (rst) begin
      cmd_q   <= DW'(CMD_RESET_VAL);
      pstart_q <= '0;
      pstop_q <= '0;
      bnd_q   <= '0;
      tpsr_q  <= '0;
      curpg_q <= '0;
      rxcfg_q <= '0;
      txcfg_q <= '0;
      dcfg_q  <= '0;
      tsr_q   <= '0;
      tcnt_q  <= '0;
      rsa_q   <= '0;
      rbc_q   <= '0;
      tx_req  <= 1'b0;
    end else begin
      tx_req <= tx_go;
      if (cmd_wr) begin
        cmd_q <= wdata;
        if (tx_go) begin
          cmd_q[CMD_TX_BIT] <= 1'b0;
        end
      end
      if (tx_go) begin
        tsr_q <= DW'(TSR_OK_VAL);
      end
      if (wr_en) begin
        case (wr_id)
          R_PSTART:  pstart_q <= wdata;
          R_PSTOP:   pstop_q <= wdata;
          R_BND:     bnd_q <= wdata;
          R_TPSR:    tpsr_q <= wdata;
          R_TCNT_LO: tcnt_q[DW-1:0] <= wdata;
          R_TCNT_HI: tcnt_q[2*DW-1:DW] <= wdata;
          R_RSA_LO:  rsa_q[DW-1:0] <= wdata;
          R_RSA_HI:  rsa_q[2*DW-1:DW] <= wdata;
          R_RBC_LO:  rbc_q[DW-1:0] <= wdata;
          R_RBC_HI:  rbc_q[2*DW-1:DW] <= wdata;
          R_RXCFG:   rxcfg_q <= wdata;
          R_TXCFG:   txcfg_q <= wdata;
          R_DCFG:    dcfg_q <= wdata;
          R_CURPG:   curpg_q <= wdata;
          default: ;
        endcase
      end
    end
  end

  nic_byte_bank #(
    .N(MAC_BYTES), .DW(DW), .IDXW(IDXW), .RESET_VAL(8'h00)
  ) u_mac (
    .clk(clk), .rst(rst), .we(wr_en && (wr_id == R_MAC)),
    .widx(wr_idx), .wdata(wdata), .q(mac_q)
  );

  nic_byte_bank #(
    .N(MCAST_BYTES), .DW(DW), .IDXW(IDXW), .RESET_VAL(8'hFF)
  ) u_mcast (
    .clk(clk), .rst(rst), .we(wr_en && (wr_id == R_MCAST)),
    .widx(wr_idx), .wdata(wdata), .q(mcast_q)
  );

  nic_irq_ctrl #(.DW(DW)) u_irq (
    .clk(clk), .rst(rst),
    .st_w1c(wr_en && (wr_id == R_ISR)),
    .mask_wr(wr_en && (wr_id == R_IMR)),
    .wdata(wdata),
    .clr_rst_bit(run_wr),
    .set_tx(tx_go),
    .set_dma(dma_go),
    .status(isr_q),
    .mask(imr_q),
    .irq(irq)
  );

  always_comb begin
    case (rd_id)
      R_CMD:    rd_val = cmd_q;
      R_PSTART: rd_val = pstart_q;
      R_PSTOP:  rd_val = pstop_q;
      R_BND:    rd_val = bnd_q;
      R_TPSR:   rd_val = tpsr_q;
      R_TSR:    rd_val = tsr_q;
      R_ISR:    rd_val = isr_q;
      R_IMR:    rd_val = imr_q;
      R_RSA_LO: rd_val = rsa_q[DW-1:0];
      R_RSA_HI: rd_val = rsa_q[2*DW-1:DW];
      R_RXCFG:  rd_val = rxcfg_q;
      R_TXCFG:  rd_val = txcfg_q;
      R_DCFG:   rd_val = dcfg_q;
      R_CURPG:  rd_val = curpg_q;
      R_MAC:    rd_val = mac_q[rd_idx];
      R_MCAST:  rd_val = mcast_q[rd_idx];
      default:  rd_val = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      rdata   <= '0;
      acc_err <= 1'b0;
    end else begin
      if (rd_en) begin
        rdata <= rd_val;
      end
      acc_err <= (wr_en && (wr_id == R_NONE)) || (rd_en && (rd_id == R_NONE));
    end
  end

  assign tx_page = tpsr_q;
  assign tx_len  = tcnt_q;

endmodule

// File: rtl/nic_regfile_chk.sv
module nic_regfile_chk #(
  parameter int DW = 8,
  parameter int AW = 4
) (
  input logic          clk,
  input logic          rst,
  input logic          wr_en,
  input logic          rd_en,
  input logic [AW-1:0] addr,
  input logic [DW-1:0] wdata,
  input logic          irq,
  input logic          acc_err,
  input logic          tx_req,
  input logic [DW-1:0] cmd_q,
  input logic [DW-1:0] isr_q,
  input logic [DW-1:0] imr_q
);

  logic [1:0] page;
  assign page = cmd_q[7:6];

  assert_irq_follows_R6: assert property (@(posedge clk) disable iff (rst)
    irq == (|(isr_q[6:0] & imr_q[6:0])));

  assert_w1c_clears_R5: assert property (@(posedge clk) disable iff (rst)
    (wr_en && page == 2'd0 && addr == AW'(7))
    |=> ((isr_q[6:0] & $past(wdata[6:0])) == 7'd0));

  assert_rst_bit_never_rises_R7: assert property (@(posedge clk) disable iff (rst)
    !$rose(isr_q[7]));

  assert_tx_selfclear_R8: assert property (@(posedge clk) disable iff (rst)
    (wr_en && addr == '0 && !wdata[0] && wdata[2])
    |=> (!cmd_q[2] && isr_q[1] && tx_req));

  assert_tx_req_status_R13: assert property (@(posedge clk) disable iff (rst)
    tx_req |-> isr_q[1]);

  assert_page3_err_R10: assert property (@(posedge clk) disable iff (rst)
    ((wr_en || rd_en) && page == 2'd3 && addr != '0) |=> acc_err);

  assert_page3_nowrite_R10: assert property (@(posedge clk) disable iff (rst)
    (wr_en && page == 2'd3 && addr != '0)
    |=> ($stable(isr_q) && $stable(imr_q) && $stable(cmd_q)));

endmodule

bind nic_regfile nic_regfile_chk #(.DW(DW), .AW(AW)) u_chk (
  .clk(clk), .rst(rst), .wr_en(wr_en), .rd_en(rd_en), .addr(addr),
  .wdata(wdata), .irq(irq), .acc_err(acc_err), .tx_req(tx_req),
  .cmd_q(cmd_q), .isr_q(isr_q), .imr_q(imr_q)
);

// File: tb/nic_regfile_bench.sv
module nic_regfile_bench;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        wr_en = 1'b0;
  logic        rd_en = 1'b0;
  logic [3:0]  addr = '0;
  logic [7:0]  wdata = '0;
  logic [7:0]  rdata;
  logic        irq, acc_err, tx_req;
  logic [7:0]  tx_page;
  logic [15:0] tx_len;

  int checks = 0;
  int failures = 0;

  always #2 clk = ~clk;

  nic_regfile u_nic_regfile (
    .clk(clk), .rst(rst), .wr_en(wr_en), .rd_en(rd_en), .addr(addr),
    .wdata(wdata), .rdata(rdata), .irq(irq), .acc_err(acc_err),
    .tx_req(tx_req), .tx_page(tx_page), .tx_len(tx_len)
  );

  task automatic chk(input string req, input logic [31:0] got, input logic [31:0] exp);
    checks++;
    if (got !== exp) begin
      failures++;
      $display("FAIL %s got=%h exp=%h", req, got, exp);
    end
  endtask

  // returns at the falling edge after the sampling edge
  task automatic wr(input logic [3:0] a, input logic [7:0] d);
    @(negedge clk);
    wr_en = 1'b1; addr = a; wdata = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic rd(input logic [3:0] a, output logic [7:0] d, output logic e);
    @(negedge clk);
    rd_en = 1'b1; addr = a;
    @(negedge clk);
    rd_en = 1'b0;
    d = rdata;
    e = acc_err;
  endtask

  task automatic rd_chk(input string req, input logic [3:0] a, input logic [7:0] exp);
    logic [7:0] d;
    logic e;
    rd(a, d, e);
    chk(req, {24'd0, d}, {24'd0, exp});
    chk({req, " no error flag"}, {31'd0, e}, 32'd0);
  endtask

  task automatic t_reset();
    chk("R1 irq low", {31'd0, irq}, 32'd0);
    chk("R1 tx_req low", {31'd0, tx_req}, 32'd0);
    rd_chk("R1 command", 4'h0, 8'h22);
    rd_chk("R1 status", 4'h7, 8'h80);
    wr(4'h7, 8'hFF);
    rd_chk("R5 bit7 kept", 4'h7, 8'h80);
    wr(4'hF, 8'hFF);
    chk("R6 bit7 no irq", {31'd0, irq}, 32'd0);
    wr(4'hF, 8'h00);
    wr(4'h0, 8'h81);
    rd_chk("R1 mask", 4'hF, 8'h00);
    wr(4'h0, 8'h41);
    rd_chk("R2 command on page1", 4'h0, 8'h41);
    for (int i = 8; i < 16; i++) rd_chk("R1 multicast", 4'(i), 8'hFF);
  endtask

  task automatic t_rst_bit();
    wr(4'h0, 8'h01);
    rd_chk("R7 stop keeps bit7", 4'h7, 8'h80);
    wr(4'h0, 8'h02);
    rd_chk("R7 run clears bit7", 4'h7, 8'h00);
  endtask

  task automatic t_cfg();
    wr(4'h1, 8'h46); wr(4'h2, 8'h80); wr(4'h3, 8'h4C); wr(4'h4, 8'h40);
    wr(4'h8, 8'h34); wr(4'h9, 8'h12);
    wr(4'hC, 8'h04); wr(4'hD, 8'h02); wr(4'hE, 8'h48);
    rd_chk("R3 boundary", 4'h3, 8'h4C);
    rd_chk("R12 remote addr lo", 4'h8, 8'h34);
    rd_chk("R12 remote addr hi", 4'h9, 8'h12);
    rd_chk("R12 off1 zero", 4'h1, 8'h00);
    rd_chk("R12 off2 zero", 4'h2, 8'h00);
    rd_chk("R12 off5 zero", 4'h5, 8'h00);
    rd_chk("R12 off6 zero", 4'h6, 8'h00);
    rd_chk("R12 offC zero", 4'hC, 8'h00);
    rd_chk("R12 offD zero", 4'hD, 8'h00);
    rd_chk("R12 offE zero", 4'hE, 8'h00);
    rd_chk("R12 offF zero", 4'hF, 8'h00);
    wr(4'h0, 8'h82);
    rd_chk("R3 ring start", 4'h1, 8'h46);
    rd_chk("R3 ring stop", 4'h2, 8'h80);
    rd_chk("R3 tx page", 4'h4, 8'h40);
    rd_chk("R3 rx cfg", 4'hC, 8'h04);
    rd_chk("R3 tx cfg", 4'hD, 8'h02);
    rd_chk("R3 data cfg", 4'hE, 8'h48);
    rd_chk("R3 mask", 4'hF, 8'h00);
  endtask

  task automatic t_page1();
    wr(4'h0, 8'h42);
    for (int i = 1; i < 16; i++) wr(4'(i), 8'(8'h90 + i));
    for (int i = 1; i < 16; i++) rd_chk("R4 page1 byte", 4'(i), 8'(8'h90 + i));
    wr(4'h0, 8'h02);
    rd_chk("R4 page0 offset7 is status", 4'h7, 8'h00);
  endtask

  task automatic t_tx();
    wr(4'h5, 8'hEA); wr(4'h6, 8'h05);
    wr(4'h0, 8'h06);
    chk("R13 tx_req pulse", {31'd0, tx_req}, 32'd1);
    chk("R13 tx_page", {24'd0, tx_page}, 32'h40);
    chk("R13 tx_len", {16'd0, tx_len}, 32'h05EA);
    @(negedge clk);
    chk("R13 tx_req one cycle", {31'd0, tx_req}, 32'd0);
    rd_chk("R8 command self-clear", 4'h0, 8'h02);
    rd_chk("R8 tx status", 4'h4, 8'h01);
    rd_chk("R8 status bit1", 4'h7, 8'h02);
    chk("R6 masked off", {31'd0, irq}, 32'd0);
    wr(4'hF, 8'h02);
    chk("R6 irq on mask", {31'd0, irq}, 32'd1);
    wr(4'h7, 8'h02);
    chk("R6 irq off after clear", {31'd0, irq}, 32'd0);
    wr(4'hF, 8'h00);
  endtask

  task automatic t_dma();
    wr(4'hA, 8'h00); wr(4'hB, 8'h00);
    wr(4'h0, 8'h0A);
    rd_chk("R9 read cmd zero count", 4'h7, 8'h40);
    wr(4'h7, 8'h04);
    rd_chk("R5 unrelated clear kept", 4'h7, 8'h40);
    wr(4'h7, 8'h40);
    rd_chk("R5 w1c", 4'h7, 8'h00);
    wr(4'h0, 8'h22);
    rd_chk("R9 abort no set", 4'h7, 8'h00);
    wr(4'hA, 8'h05);
    wr(4'h0, 8'h12);
    rd_chk("R9 nonzero count no set", 4'h7, 8'h00);
    wr(4'hA, 8'h00);
    wr(4'h0, 8'h19);
    wr(4'h0, 8'h19);
    rd_chk("R9 stop no set", 4'h7, 8'h00);
    wr(4'h0, 8'h1A);
    rd_chk("R9 send zero count", 4'h7, 8'h40);
    wr(4'h7, 8'h40);
    wr(4'h0, 8'h02);
  endtask

  task automatic t_bad();
    logic [7:0] d;
    logic e;
    wr(4'h0, 8'hC2);
    rd_chk("R2 command on page3", 4'h0, 8'hC2);
    wr(4'h3, 8'h77);
    chk("R10 page3 write flag", {31'd0, acc_err}, 32'd1);
    rd(4'h3, d, e);
    chk("R10 page3 read zero", {24'd0, d}, 32'd0);
    chk("R10 page3 read flag", {31'd0, e}, 32'd1);
    @(negedge clk);
    chk("R10 flag one cycle", {31'd0, acc_err}, 32'd0);
    wr(4'h0, 8'h02);
    rd_chk("R10 boundary untouched", 4'h3, 8'h4C);
    rd(4'hA, d, e);
    chk("R12 offA unmapped read", {24'd0, d}, 32'd0);
    chk("R12 offA flag", {31'd0, e}, 32'd1);
    wr(4'h0, 8'h82);
    wr(4'h1, 8'h11);
    chk("R10 page2 write flag", {31'd0, acc_err}, 32'd1);
    rd_chk("R10 page2 write ignored", 4'h1, 8'h46);
    wr(4'h0, 8'h02);
  endtask

  task automatic t_hold();
    rd_chk("R11 read boundary", 4'h3, 8'h4C);
    wr(4'h3, 8'h11);
    repeat (3) @(negedge clk);
    chk("R11 rdata holds", {24'd0, rdata}, 32'h4C);
    rd_chk("R11 new read", 4'h3, 8'h11);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    t_reset();
    t_rst_bit();
    t_cfg();
    t_page1();
    t_tx();
    t_dma();
    t_bad();
    t_hold();
    repeat (2) @(negedge clk);
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    checks++;
    failures++;
    $display("FAIL watchdog expired");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

endmodule